// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the part of an 8-bit processor core that moves the machine into and out of its exception paths. It drives one memory request per cycle on a 16-bit address bus and uses whatever byte the memory returns in that cycle. It owns the program counter, the stack pointer and the status register. It walks the power-up vector fetch, the maskable-interrupt and software-break entries, and the return-from-interrupt pull sequence, and it performs every opcode fetch.

When a fetched opcode is neither the break nor the return opcode, the sequencer hands the instruction to the execution logic through a start/finish handshake and keeps the bus idle until it is told the instruction is finished. The last cycle of every sequence is an instruction boundary. At that boundary a pending interrupt request is accepted in place of the next opcode fetch, provided interrupts are not masked.

The status byte is laid out with N in bit 7, V in bit 6, a reserved bit in bit 5, B in bit 4, D in bit 3, I in bit 2, Z in bit 1 and C in bit 0. The stack lives in page 0x01.

Top module: `irqseq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the bus reads 0xFFFC, then reads 0xFFFD. The PC is loaded with {byte@0xFFFD, byte@0xFFFC}, the stack pointer is 0xFF and the status byte is 0x00.
- R2: `sync` is high only in an opcode fetch cycle. That cycle reads at the PC, and the PC advances by one after it.
- R3: At an instruction boundary, a pending request is accepted only when status bit 2 (I) is 0. When it is accepted, the entry starts in the next cycle with no opcode fetch before it.
- R4: An entry writes PC[15:8], then PC[7:0], then the status byte, each to {0x01, S}. S is decremented after every write.
- R5: After the status write, I becomes 1. The next two cycles read 0xFFFE (new PC low) and 0xFFFF (new PC high).
- R6: Opcode 0x00 (break) causes one read at PC+1 that is skipped, so the pushed return address is the break address plus two.
- R7: The pushed status has bit 5 set and bit 4 set for a break or clear for a hardware request. A break clears D (bit 3) and a hardware request leaves D unchanged.
- R8: Opcode 0x40 (return) does one dummy read at the PC. It then pulls the status from {0x01, S+1} with bits 5 and 4 forced to 1, and then pulls PC low and PC high from the next two incremented stack addresses.
- R9: A request pulse that arrives while I is 1 is kept pending. It is accepted at the first boundary where I is 0.
- R10: S counts modulo 256, so every stack access stays in 0x0100–0x01FF. A pull with S = 0xFF reads 0x0100.
- R11: For any other opcode, `exec_go` is high from the cycle after the fetch until and including the cycle with `exec_done` high. `bus_en` is low during that time, and that cycle is the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request pulse |
| exec_done | input | 1 | Execution logic finished the current instruction |
| bus_rdata | input | 8 | Read data for the request of this cycle |
| bus_en | output | 1 | A bus request is made this cycle |
| bus_we | output | 1 | The request is a write |
| bus_addr | output | 16 | Request address |
| bus_wdata | output | 8 | Write data |
| sync | output | 1 | Opcode fetch cycle |
| exec_go | output | 1 | Instruction handed to the execution logic |
| opcode | output | 8 | Last fetched opcode |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Status byte |

## Verification
Two collisions are provoked deliberately. In the first, a request pulse lands in the very cycle that fetches a break opcode. The break's own entry must win with B pushed as 1, and the hardware request must then wait, masked, until the return restores I = 0. In the second, a request raised inside a handler coincides with the return's final pull cycle, which is also a boundary. The bench expects the new entry to follow immediately, with no opcode fetch in between. A behavioural reference model predicts every bus cycle, register value and push byte, and it is compared against the outputs on each clock.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

    localparam int AW = 16;
    localparam int DW = 8;

    localparam logic [AW-1:0] DEF_RST_VEC  = 16'hFFFC;
    localparam logic [AW-1:0] DEF_IRQ_VEC  = 16'hFFFE;
    localparam logic [DW-1:0] DEF_STK_PAGE = 8'h01;
    localparam logic [DW-1:0] SP_INIT      = 8'hFF;
    localparam logic [DW-1:0] OPC_BREAK    = 8'h00;
    localparam logic [DW-1:0] OPC_RETURN   = 8'h40;

    typedef struct packed {
        logic n;
        logic v;
        logic r;
        logic b;
        logic d;
        logic i;
        logic z;
        logic c;
    } stat_t;

    typedef enum logic [3:0] {
        S_RLO, S_RHI, S_FETCH, S_EXEC, S_SKIP,
        S_PSH_H, S_PSH_L, S_PSH_P, S_VLO, S_VHI,
        S_RDUM, S_PUL_P, S_PUL_L, S_PUL_H
    } st_e;

    typedef enum logic [2:0] {A_PC, A_PUSH, A_PULL, A_VEC_LO, A_VEC_HI} asel_e;
    typedef enum logic [1:0] {W_PCH, W_PCL, W_STAT} wsel_e;
    typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} spop_e;
    typedef enum logic [1:0] {F_HOLD, F_ENTER_IRQ, F_ENTER_BRK, F_PULL} fop_e;
    typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_LOAD} pcop_e;

    typedef struct packed {
        asel_e asel;
        logic  vec_rst;
        logic  bus_en;
        logic  we;
        wsel_e wsel;
        spop_e spop;
        fop_e  fop;
        pcop_e pcop;
        logic  cap_lo;
        logic  sync;
        logic  go;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{asel: A_PC, vec_rst: 1'b0, bus_en: 1'b0, we: 1'b0,
                                  wsel: W_PCH, spop: SP_HOLD, fop: F_HOLD,
                                  pcop: PC_HOLD, cap_lo: 1'b0, sync: 1'b0, go: 1'b0};

    function automatic logic [DW-1:0] push_image(stat_t p, logic brk);
        return {p.n, p.v, 1'b1, brk, p.d, p.i, p.z, p.c};
    endfunction

    function automatic stat_t pull_image(logic [DW-1:0] d);
        stat_t s;
        s   = stat_t'(d);
        s.r = 1'b1;
        s.b = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/irqseq_stack.sv
module irqseq_stack
    import irqseq_pkg::*;
#(
    parameter logic [DW-1:0] STK_PAGE = DEF_STK_PAGE
) (
    input  logic          clk,
    input  logic          rst,
    input  spop_e         spop,
    output logic [DW-1:0] sp,
    output logic [AW-1:0] push_addr,
    output logic [AW-1:0] pull_addr
);
    logic [DW-1:0] sp_q;
    logic [DW-1:0] sp_inc;

    assign sp_inc    = sp_q + 8'd1;
    assign sp        = sp_q;
    assign push_addr = {STK_PAGE, sp_q};
    assign pull_addr = {STK_PAGE, sp_inc};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_INIT;
        end else begin
            unique case (spop)
                SP_DEC:  sp_q <= sp_q - 8'd1;
                SP_INC:  sp_q <= sp_inc;
                default: sp_q <= sp_q;
            endcase
        end
    end

    AST_SP_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (spop == SP_INC) |=> (sp_q == $past(sp_q) + 8'd1)); // R10
    AST_SP_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (spop == SP_DEC) |=> (sp_q == $past(sp_q) - 8'd1)); // R4

endmodule

// File: rtl/irqseq_status.sv
module irqseq_status
    import irqseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  fop_e          fop,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] stat_byte,
    output logic [DW-1:0] push_byte,
    output logic          i_flag
);
    stat_t st_q;

    assign stat_byte = st_q;
    assign i_flag    = st_q.i;
    assign push_byte = push_image(st_q, fop == F_ENTER_BRK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            unique case (fop)
                F_ENTER_IRQ: st_q.i <= 1'b1;
                F_ENTER_BRK: begin
                    st_q.i <= 1'b1;
                    st_q.d <= 1'b0;
                end
                F_PULL:  st_q <= pull_image(rdata);
                default: st_q <= st_q;
            endcase
        end
    end

    AST_MASK_AFTER_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (fop == F_ENTER_IRQ || fop == F_ENTER_BRK) |=> st_q.i); // R5
    AST_BREAK_CLEARS_D: assert property (@(posedge clk) disable iff (rst)
        (fop == F_ENTER_BRK) |=> !st_q.d); // R7
    AST_IRQ_KEEPS_D: assert property (@(posedge clk) disable iff (rst)
        (fop == F_ENTER_IRQ) |=> (st_q.d == $past(st_q.d))); // R7
    AST_PULL_FORCES_BITS: assert property (@(posedge clk) disable iff (rst)
        (fop == F_PULL) |=> (st_q.b && st_q.r)); // R8

endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
    import irqseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_req,
    input  logic          exec_done,
    input  logic          i_flag,
    input  logic [DW-1:0] rdata,
    output ctl_t          ctl
);
    st_e  st_q, st_d;
    logic pend_q, pend_d;
    logic brk_q, brk_d;
    logic bound, take;

    always_comb begin
        ctl   = CTL_IDLE;
        st_d  = st_q;
        brk_d = brk_q;
        bound = 1'b0;
        unique case (st_q)
            S_RLO: begin
                ctl.asel = A_VEC_LO; ctl.vec_rst = 1'b1; ctl.bus_en = 1'b1;
                ctl.cap_lo = 1'b1;
                st_d = S_RHI;
            end
            S_RHI: begin
                ctl.asel = A_VEC_HI; ctl.vec_rst = 1'b1; ctl.bus_en = 1'b1;
                ctl.pcop = PC_LOAD;
                bound = 1'b1;
            end
            S_FETCH: begin
                ctl.bus_en = 1'b1; ctl.sync = 1'b1; ctl.pcop = PC_INC;
                if (rdata == OPC_BREAK)       st_d = S_SKIP;
                else if (rdata == OPC_RETURN) st_d = S_RDUM;
                else                          st_d = S_EXEC;
            end
            S_EXEC: begin
                ctl.go = 1'b1;
                bound  = exec_done;
            end
            S_SKIP: begin
                ctl.bus_en = 1'b1; ctl.pcop = PC_INC;
                brk_d = 1'b1;
                st_d  = S_PSH_H;
            end
            S_PSH_H: begin
                ctl.asel = A_PUSH; ctl.bus_en = 1'b1; ctl.we = 1'b1;
                ctl.wsel = W_PCH; ctl.spop = SP_DEC;
                st_d = S_PSH_L;
            end
            S_PSH_L: begin
                ctl.asel = A_PUSH; ctl.bus_en = 1'b1; ctl.we = 1'b1;
                ctl.wsel = W_PCL; ctl.spop = SP_DEC;
                st_d = S_PSH_P;
            end
            S_PSH_P: begin
                ctl.asel = A_PUSH; ctl.bus_en = 1'b1; ctl.we = 1'b1;
                ctl.wsel = W_STAT; ctl.spop = SP_DEC;
                ctl.fop  = brk_q ? F_ENTER_BRK : F_ENTER_IRQ;
                brk_d = 1'b0;
                st_d  = S_VLO;
            end
            S_VLO: begin
                ctl.asel = A_VEC_LO; ctl.bus_en = 1'b1; ctl.cap_lo = 1'b1;
                st_d = S_VHI;
            end
            S_VHI: begin
                ctl.asel = A_VEC_HI; ctl.bus_en = 1'b1; ctl.pcop = PC_LOAD;
                bound = 1'b1;
            end
            S_RDUM: begin
                ctl.bus_en = 1'b1;
                st_d = S_PUL_P;
            end
            S_PUL_P: begin
                ctl.asel = A_PULL; ctl.bus_en = 1'b1; ctl.spop = SP_INC;
                ctl.fop  = F_PULL;
                st_d = S_PUL_L;
            end
            S_PUL_L: begin
                ctl.asel = A_PULL; ctl.bus_en = 1'b1; ctl.spop = SP_INC;
                ctl.cap_lo = 1'b1;
                st_d = S_PUL_H;
            end
            S_PUL_H: begin
                ctl.asel = A_PULL; ctl.bus_en = 1'b1; ctl.spop = SP_INC;
                ctl.pcop = PC_LOAD;
                bound = 1'b1;
            end
            default: st_d = S_FETCH;
        endcase

        take   = bound & (pend_q | irq_req) & ~i_flag;
        pend_d = take ? 1'b0 : (pend_q | irq_req);
        if (bound) st_d = take ? S_PSH_H : S_FETCH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_RLO;
            pend_q <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            brk_q  <= brk_d;
        end
    end

    AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (bound && i_flag) |=> (st_q != S_PSH_H)); // R3
    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
        (pend_q && i_flag) |=> pend_q); // R9
    AST_ENTRY_FROM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PSH_H) |-> ($past(bound) || $past(st_q) == S_SKIP)); // R3

endmodule

// File: rtl/irqseq_top.sv
module irqseq_top
    import irqseq_pkg::*;
#(
    parameter logic [AW-1:0] RST_VEC  = DEF_RST_VEC,
    parameter logic [AW-1:0] IRQ_VEC  = DEF_IRQ_VEC,
    parameter logic [DW-1:0] STK_PAGE = DEF_STK_PAGE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_req,
    input  logic          exec_done,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_en,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          sync,
    output logic          exec_go,
    output logic [DW-1:0] opcode,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] status_out
);
    ctl_t          ctl;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] op_q;
    logic [AW-1:0] push_addr, pull_addr, vec_base;
    logic [DW-1:0] push_byte;
    logic          i_flag;

    irqseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req), .exec_done(exec_done),
        .i_flag(i_flag), .rdata(bus_rdata), .ctl(ctl)
    );

    irqseq_stack #(.STK_PAGE(STK_PAGE)) u_stack (
        .clk(clk), .rst(rst), .spop(ctl.spop), .sp(sp_out),
        .push_addr(push_addr), .pull_addr(pull_addr)
    );

    irqseq_status u_status (
        .clk(clk), .rst(rst), .fop(ctl.fop), .rdata(bus_rdata),
        .stat_byte(status_out), .push_byte(push_byte), .i_flag(i_flag)
    );

    assign vec_base = ctl.vec_rst ? RST_VEC : IRQ_VEC;

    always_comb begin
        unique case (ctl.asel)
            A_PUSH:   bus_addr = push_addr;
            A_PULL:   bus_addr = pull_addr;
            A_VEC_LO: bus_addr = vec_base;
            A_VEC_HI: bus_addr = vec_base + 16'd1;
            default:  bus_addr = pc_q;
        endcase
        unique case (ctl.wsel)
            W_PCL:   bus_wdata = pc_q[7:0];
            W_STAT:  bus_wdata = push_byte;
            default: bus_wdata = pc_q[15:8];
        endcase
    end

    assign bus_en  = ctl.bus_en;
    assign bus_we  = ctl.we;
    assign sync    = ctl.sync;
    assign exec_go = ctl.go;
    assign opcode  = op_q;
    assign pc_out  = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            lo_q <= '0;
            op_q <= '0;
        end else begin
            if (ctl.cap_lo) lo_q <= bus_rdata;
            if (ctl.sync)   op_q <= bus_rdata;
            unique case (ctl.pcop)
                PC_INC:  pc_q <= pc_q + 16'd1;
                PC_LOAD: pc_q <= {bus_rdata, lo_q};
                default: pc_q <= pc_q;
            endcase
        end
    end

    AST_RESET_READS_VECTOR: assert property (@(posedge clk)
        $past(rst) |-> (bus_en && !bus_we && bus_addr == RST_VEC)); // R1
    AST_STACK_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> (bus_addr[15:8] == STK_PAGE)); // R10
    AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> (sp_out == $past(sp_out) - 8'd1)); // R4
    AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (rst)
        sync |=> (pc_q == $past(pc_q) + 16'd1)); // R2
    AST_GO_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        exec_go |-> !bus_en); // R11

endmodule

// File: tb/test_irqseq_top.sv
module test_irqseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic        exec_done;
    logic [7:0]  bus_rdata;
    logic        bus_en, bus_we, sync, exec_go;
    logic [15:0] bus_addr, pc_out;
    logic [7:0]  bus_wdata, opcode, sp_out, status_out;

    int n_tests = 0;
    int n_fail  = 0;
    int n_wr    = 0;
    bit model_on   = 1'b1;
    bit model_idle = 1'b0;
    bit finished   = 1'b0;
    logic ex_seen = 1'b0;

    logic [7:0] stk [256];
    logic [7:0] prg [256];
    logic [7:0] hnd [256];

    always #5 clk = ~clk;

    irqseq_top i_irqseq_top (
        .clk(clk), .rst(rst), .irq_req(irq_req), .exec_done(exec_done),
        .bus_rdata(bus_rdata), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sync(sync),
        .exec_go(exec_go), .opcode(opcode), .pc_out(pc_out),
        .sp_out(sp_out), .status_out(status_out)
    );

    function automatic logic [7:0] rd(input logic [15:0] a);
        case (a[15:8])
            8'h01:   return stk[a[7:0]];
            8'h02:   return prg[a[7:0]];
            8'h03:   return hnd[a[7:0]];
            8'hFF: begin
                case (a[7:0])
                    8'hFC:   return 8'h00;
                    8'hFD:   return 8'h02;
                    8'hFE:   return 8'h00;
                    8'hFF:   return 8'h03;
                    default: return 8'hEA;
                endcase
            end
            default: return 8'hEA;
        endcase
    endfunction

    always_comb bus_rdata = rd(bus_addr);
    assign exec_done = exec_go & ex_seen;

    always @(posedge clk) begin
        ex_seen <= exec_go & ~exec_done;
        if (!rst && bus_en && bus_we) begin
            n_wr <= n_wr + 1;
            if (bus_addr[15:8] == 8'h01) stk[bus_addr[7:0]] <= bus_wdata;
        end
    end

    logic [15:0] m_pc;
    logic [7:0]  m_sp, m_p, lo, op;
    bit          pend, take;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [15:0] a, input bit en, input bit w,
                       input logic [7:0] d, input bit s, input bit go,
                       input bit bnd_in, input bit use_done, input string tag,
                       output bit bnd);
        bit ok;
        @(negedge clk);
        ok = (bus_en === en) && (!en || bus_addr === a) && (bus_we === w) &&
             (!w || bus_wdata === d) && (sync === s) && (exec_go === go) &&
             (pc_out === m_pc) && (sp_out === m_sp) && (status_out === m_p);
        check(ok, tag, "bus{en,we,sync,go,addr,wd}/pc/sp/st",
              {bus_en, bus_we, sync, exec_go, bus_addr, bus_wdata} ^ {pc_out, sp_out, status_out},
              {en, w, s, go, a, d} ^ {m_pc, m_sp, m_p});
        if (!ok)
            $display("     detail: addr=%h en=%b we=%b wd=%h sync=%b go=%b pc=%h sp=%h st=%h | exp addr=%h en=%b we=%b wd=%h sync=%b go=%b pc=%h sp=%h st=%h",
                     bus_addr, bus_en, bus_we, bus_wdata, sync, exec_go, pc_out, sp_out, status_out,
                     a, en, w, d, s, go, m_pc, m_sp, m_p);
        bnd = use_done ? (exec_done === 1'b1) : bnd_in;
        take = 1'b0;
        if (bnd) begin
            take = (pend || irq_req) && !m_p[2];
            pend = take ? 1'b0 : (pend || irq_req);
        end else begin
            pend = pend || irq_req;
        end
    endtask

    task automatic entry(input bit brk);
        bit b;
        cyc({8'h01, m_sp}, 1, 1, m_pc[15:8], 0, 0, 0, 0, "R4", b);
        m_sp = m_sp - 8'd1;
        cyc({8'h01, m_sp}, 1, 1, m_pc[7:0], 0, 0, 0, 0, "R4", b);
        m_sp = m_sp - 8'd1;
        cyc({8'h01, m_sp}, 1, 1, {m_p[7:6], 1'b1, brk, m_p[3:0]}, 0, 0, 0, 0, "R7", b);
        m_sp = m_sp - 8'd1;
        m_p[2] = 1'b1;
        if (brk) m_p[3] = 1'b0;
        cyc(16'hFFFE, 1, 0, 8'h00, 0, 0, 0, 0, "R5", b);
        lo = rd(16'hFFFE);
        cyc(16'hFFFF, 1, 0, 8'h00, 0, 0, 1, 0, "R5", b);
        m_pc = {rd(16'hFFFF), lo};
    endtask

    task automatic rti();
        bit b;
        logic [15:0] a;
        cyc(m_pc, 1, 0, 8'h00, 0, 0, 0, 0, "R8", b);
        a = {8'h01, m_sp + 8'd1};
        cyc(a, 1, 0, 8'h00, 0, 0, 0, 0, "R10", b);
        m_sp = m_sp + 8'd1;
        m_p = rd(a) | 8'h30;
        a = {8'h01, m_sp + 8'd1};
        cyc(a, 1, 0, 8'h00, 0, 0, 0, 0, "R8", b);
        m_sp = m_sp + 8'd1;
        lo = rd(a);
        a = {8'h01, m_sp + 8'd1};
        cyc(a, 1, 0, 8'h00, 0, 0, 1, 0, "R3 R8", b);
        m_sp = m_sp + 8'd1;
        m_pc = {rd(a), lo};
    endtask

    initial begin : model
        bit b;
        m_pc = 16'h0000; m_sp = 8'hFF; m_p = 8'h00; pend = 1'b0; take = 1'b0;
        wait (rst == 1'b0);
        cyc(16'hFFFC, 1, 0, 8'h00, 0, 0, 0, 0, "R1", b);
        lo = rd(16'hFFFC);
        cyc(16'hFFFD, 1, 0, 8'h00, 0, 0, 1, 0, "R1", b);
        m_pc = {rd(16'hFFFD), lo};
        while (model_on) begin
            if (take) begin
                entry(1'b0);
            end else begin
                cyc(m_pc, 1, 0, 8'h00, 1, 0, 0, 0, "R2", b);
                op = rd(m_pc);
                m_pc = m_pc + 16'd1;
                if (op == 8'h00) begin
                    cyc(m_pc, 1, 0, 8'h00, 0, 0, 0, 0, "R6", b);
                    m_pc = m_pc + 16'd1;
                    entry(1'b1);
                end else if (op == 8'h40) begin
                    rti();
                end else begin
                    b = 1'b0;
                    while (!b) cyc(m_pc, 0, 0, 8'h00, 0, 1, 0, 1, "R11", b);
                end
            end
        end
        model_idle = 1'b1;
    end

    task automatic wait_fetch(input logic [15:0] a);
        do @(negedge clk); while (!(sync === 1'b1 && bus_addr === a));
    endtask

    task automatic pulse_irq();
        @(posedge clk); #1 irq_req = 1'b1;
        @(posedge clk); #1 irq_req = 1'b0;
    endtask

    initial begin : stim
        for (int k = 0; k < 256; k++) begin
            prg[k] = 8'hEA; hnd[k] = 8'hEA; stk[k] = 8'h00;
        end
        prg[8'h00] = 8'h40;                       // return right after reset: wraps S
        stk[8'h00] = 8'h08; stk[8'h01] = 8'h10; stk[8'h02] = 8'h02;
        prg[8'h12] = 8'h00; prg[8'h13] = 8'h55;   // first break
        prg[8'h20] = 8'h00; prg[8'h21] = 8'h77;   // second break
        hnd[8'h01] = 8'h40;

        @(posedge clk); @(negedge clk);
        check(bus_addr === 16'hFFFC && bus_en === 1'b1 && bus_we === 1'b0, "R1",
              "addr during reset", bus_addr, 16'hFFFC);
        check(sp_out === 8'hFF && status_out === 8'h00, "R1",
              "sp/status during reset", {sp_out, status_out}, 16'hFF00);
        @(posedge clk); #1 rst = 1'b0;

        wait_fetch(16'h0216);
        pulse_irq();                                 // accepted at once, I = 0
        wait_fetch(16'h0300);
        check(status_out[3] === 1'b1, "R7", "D kept by hardware entry", status_out[3], 1);
        pulse_irq();                                 // masked, must stay pending (R9)
        wait_fetch(16'h021F);
        repeat (3) @(posedge clk);
        #1 irq_req = 1'b1;                           // same cycle as break fetch
        @(posedge clk); #1 irq_req = 1'b0;
        wait_fetch(16'h0300);
        check(status_out[3] === 1'b0, "R7", "D cleared by break", status_out[3], 0);
        wait_fetch(16'h0228);
        model_on = 1'b0;
        wait (model_idle);

        check(n_wr == 15, "R9", "stack writes for five entries", n_wr, 15);

        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(bus_addr === 16'hFFFC && sp_out === 8'hFF && status_out === 8'h00 && bus_we === 1'b0,
              "R1", "re-reset state", {bus_addr, sp_out, status_out}, {16'hFFFC, 8'hFF, 8'h00});
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(bus_addr === 16'hFFFC, "R1", "first vector read", bus_addr, 16'hFFFC);
        @(negedge clk);
        check(bus_addr === 16'hFFFD, "R1", "second vector read", bus_addr, 16'hFFFD);
        @(negedge clk);
        check(pc_out === 16'h0200 && sync === 1'b1 && bus_addr === 16'h0200, "R2",
              "first fetch after reset", {pc_out, bus_addr}, {16'h0200, 16'h0200});

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule